// File: doc/BRIEF.md
# Indicator Test and Interrupt Unit

This unit keeps a bank of 64 sticky machine condition flags. Other units raise a flag with a one-cycle set pulse, and the flag stays raised until a branch test clears it or the block is reset. A single conditional-branch request names one flag through a 6-bit selector and carries two modifier bits. The first says whether the branch is taken when the flag is raised or when it is clear. The second asks for the flag to be cleared as a side effect of the test.

The same flags drive interruption. A mask register, as wide as the flag bank, enables each flag as an interrupt source. Whenever a flag and its mask bit are both raised, the unit requests an interrupt and reports the lowest-numbered such flag. A separately loaded base register picks the group of alternate entry points. The unit places it above the flag index to form the entry-point selector.

The branch decision and the interrupt outputs are combinational, from the current request and the registered state. All state changes happen on the rising clock edge.

Top module: `ind_test_irq`

## Requirements
- R1: A synchronous reset (`rst` high at a rising edge) clears all flags, the mask and the base, so that `irq_req` is 0 afterwards until a flag and its mask bit are both raised again.
- R2: When `test_valid` is 1 and `test_on` is 1, `br_taken` is 1 in the same cycle exactly when the flag numbered `test_sel` is raised.
- R3: When `test_valid` is 1 and `test_on` is 0, `br_taken` is 1 in the same cycle exactly when the selected flag is clear. When `test_valid` is 0, `br_taken` is 0.
- R4: When `test_valid` and `test_clear` are both 1, the selected flag is clear from the next cycle on. The branch decision in the test cycle uses the value from before the clear. With `test_valid` at 0, `test_clear` has no effect.
- R5: If a set pulse for a flag arrives in the same cycle as a clear of that flag, the flag is raised in the next cycle.
- R6: A 1 on bit i of `set_pulse` raises flag i from the next cycle on, and the flag stays raised without further pulses.
- R7: `irq_req` is 1 exactly when at least one flag is raised whose mask bit is also 1. Flags with a mask bit of 0 never cause a request.
- R8: While `irq_req` is 1, `irq_index` is the lowest flag number among the raised, unmasked flags. Flag 0 has the highest priority.
- R9: With `mask_load` at 1, `mask_data` becomes the mask from the next cycle on. The outputs in the load cycle still use the old mask.
- R10: `irq_vector` is the base register in its upper bits, followed by `irq_index` in its low 6 bits. With `base_load` at 1, `base_data` becomes the base from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| set_pulse | input | 64 | One-cycle raise request for each flag |
| test_valid | input | 1 | A branch test is presented this cycle |
| test_sel | input | 6 | Number of the flag under test |
| test_on | input | 1 | 1: taken when the flag is raised; 0: taken when it is clear |
| test_clear | input | 1 | Clear the tested flag after the test |
| mask_load | input | 1 | Load `mask_data` into the mask |
| mask_data | input | 64 | New mask value |
| base_load | input | 1 | Load `base_data` into the base register |
| base_data | input | 10 | New entry-point group base |
| br_taken | output | 1 | Branch decision for the current test |
| irq_req | output | 1 | Interrupt request |
| irq_index | output | 6 | Lowest pending unmasked flag number |
| irq_vector | output | 16 | Base and index concatenated |

## Verification
The assertions assume that `rst` is held for at least one rising edge before any input is trusted. They also assume that `test_sel` is always a defined 6-bit value, so any selector addresses a real flag. The clear check exempts a cycle in which the same flag is also pulsed, because a pulse can legally override the clear. The stimulus changes inputs only on falling edges and always drives every request field with known values. It exercises raise-and-clear collisions on purpose, so that the exempted case is reached in a controlled way.

// File: rtl/ind_test_irq.sv
module ind_test_irq #(
  parameter int NUM_IND = 64,
  parameter int BASE_W  = 10,
  localparam int SEL_W  = $clog2(NUM_IND),
  localparam int VEC_W  = BASE_W + SEL_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_IND-1:0] set_pulse,
  input  logic               test_valid,
  input  logic [SEL_W-1:0]   test_sel,
  input  logic               test_on,
  input  logic               test_clear,
  input  logic               mask_load,
  input  logic [NUM_IND-1:0] mask_data,
  input  logic               base_load,
  input  logic [BASE_W-1:0]  base_data,
  output logic               br_taken,
  output logic               irq_req,
  output logic [SEL_W-1:0]   irq_index,
  output logic [VEC_W-1:0]   irq_vector
);

  logic [NUM_IND-1:0] ind_q, mask_q, clr_vec, pend;
  logic [BASE_W-1:0]  base_q;

  assign clr_vec = (test_valid && test_clear) ? (NUM_IND'(1) << test_sel) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      ind_q  <= '0;
      mask_q <= '0;
      base_q <= '0;
    end else begin
      ind_q <= (ind_q & ~clr_vec) | set_pulse;
      if (mask_load) mask_q <= mask_data;
      if (base_load) base_q <= base_data;
    end
  end

  assign br_taken = test_valid && (ind_q[test_sel] == test_on);

  assign pend    = ind_q & mask_q;
  assign irq_req = |pend;

  always_comb begin
    irq_index = '0;
    for (int i = NUM_IND - 1; i >= 0; i--)
      if (pend[i]) irq_index = i[SEL_W-1:0];
  end

  assign irq_vector = {base_q, irq_index};

  logic [NUM_IND-1:0] below_idx;
  assign below_idx = ~({NUM_IND{1'b1}} << irq_index);

  assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (ind_q == '0 && mask_q == '0 && !irq_req));

  assert_sticky_set_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ((ind_q & $past(set_pulse)) == $past(set_pulse)));

  assert_clear_applies_R4: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(test_valid && test_clear) && !$past(set_pulse[test_sel]))
      |-> !ind_q[$past(test_sel)]);

  assert_req_source_R7: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (ind_q[irq_index] && mask_q[irq_index]));

  assert_lowest_first_R8: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> ((pend & below_idx) == '0));

  assert_mask_load_R9: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(mask_load)) |-> (mask_q == $past(mask_data)));

  assert_no_test_no_take_R3: assert property (@(posedge clk) disable iff (rst)
    !test_valid |-> !br_taken);

endmodule

// File: tb/ind_test_irq_tb_top.sv
module ind_test_irq_tb_top;
  localparam int N  = 64;
  localparam int BW = 10;
  localparam int SW = 6;

  logic clk = 0;
  always #10 clk = ~clk;

  logic          rst;
  logic [N-1:0]  set_pulse, mask_data;
  logic          test_valid, test_on, test_clear, mask_load, base_load;
  logic [SW-1:0] test_sel;
  logic [BW-1:0] base_data;
  logic          br_taken, irq_req;
  logic [SW-1:0] irq_index;
  logic [BW+SW-1:0] irq_vector;

  ind_test_irq #(.NUM_IND(N), .BASE_W(BW)) dut_i (
    .clk(clk), .rst(rst), .set_pulse(set_pulse), .test_valid(test_valid),
    .test_sel(test_sel), .test_on(test_on), .test_clear(test_clear),
    .mask_load(mask_load), .mask_data(mask_data), .base_load(base_load),
    .base_data(base_data), .br_taken(br_taken), .irq_req(irq_req),
    .irq_index(irq_index), .irq_vector(irq_vector));

  typedef struct {
    logic          taken;
    logic          irq;
    logic [SW-1:0] idx;
    logic [BW+SW-1:0] vec;
    string         tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, errors = 0;
  logic [N-1:0]  ind_m = '0, mask_m = '0;
  logic [BW-1:0] base_m = '0;

  task automatic idle_inputs();
    set_pulse = '0; test_valid = 0; test_sel = '0; test_on = 0; test_clear = 0;
    mask_load = 0; mask_data = '0; base_load = 0; base_data = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst = 0;
    ind_m = '0; mask_m = '0; base_m = '0;
  endtask

  task automatic step(input logic [N-1:0] sp, input logic tv, input logic [SW-1:0] sel,
                      input logic on, input logic clr, input logic ml,
                      input logic [N-1:0] md, input logic bl,
                      input logic [BW-1:0] bd, input string tag);
    exp_t e;
    logic [N-1:0] p;
    @(negedge clk);
    set_pulse = sp; test_valid = tv; test_sel = sel; test_on = on; test_clear = clr;
    mask_load = ml; mask_data = md; base_load = bl; base_data = bd;
    p = ind_m & mask_m;
    e.taken = tv && (ind_m[sel] == on);
    e.irq = |p;
    e.idx = '0;
    for (int i = 0; i < N; i++) if (p[i]) begin e.idx = i[SW-1:0]; break; end
    e.vec = {base_m, e.idx};
    e.tag = tag;
    exp_q.push_back(e);
    if (tv && clr) ind_m[sel] = 1'b0;
    ind_m = ind_m | sp;
    if (ml) mask_m = md;
    if (bl) base_m = bd;
  endtask

  task automatic idle(input string tag);
    step('0, 0, '0, 0, 0, 0, '0, 0, '0, tag);
  endtask

  task automatic cmp(input string tag, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        cmp(e.tag, "br_taken", 32'(br_taken), 32'(e.taken));
        cmp(e.tag, "irq_req", 32'(irq_req), 32'(e.irq));
        if (e.irq) begin
          cmp(e.tag, "irq_index", 32'(irq_index), 32'(e.idx));
          cmp(e.tag, "irq_vector", 32'(irq_vector), 32'(e.vec));
        end
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1;
    idle_inputs();
    do_reset();
    idle("R1 reset state");
    step(64'h1 << 5, 0, '0, 0, 0, 1, '1, 0, '0, "R6 R9 set 5 load mask");
    idle("R6 R9 flag 5 pending");
    step('0, 1, 6'd5, 1, 0, 0, '0, 0, '0, "R2 taken on raised");
    step('0, 1, 6'd5, 0, 0, 0, '0, 0, '0, "R3 not taken when raised");
    step('0, 1, 6'd7, 0, 0, 0, '0, 0, '0, "R3 taken on clear");
    step('0, 1, 6'd7, 1, 0, 0, '0, 0, '0, "R2 not taken on clear");
    step('0, 0, 6'd5, 1, 1, 0, '0, 0, '0, "R4 clear ignored without valid");
    step('0, 1, 6'd5, 1, 1, 0, '0, 0, '0, "R4 test uses pre-clear value");
    idle("R4 R7 flag 5 cleared");
    step(64'h1 << 9, 1, 6'd9, 1, 1, 0, '0, 0, '0, "R5 set and clear collide");
    idle("R5 set wins");
    step((64'h1 << 3) | (64'h1 << 40), 0, '0, 0, 0, 0, '0, 0, '0, "R6 set 3 and 40");
    idle("R8 lowest is 3");
    step('0, 0, '0, 0, 0, 1, ~(64'h1 << 3), 0, '0, "R9 mask load cycle uses old");
    idle("R9 R8 flag 3 masked, 9 next");
    step('0, 0, '0, 0, 0, 0, '0, 1, 10'h2A5, "R10 base load cycle");
    idle("R10 vector uses base");
    step(64'h1 << 63, 0, '0, 0, 0, 1, 64'h1 << 63, 0, '0, "R9 mask only 63");
    idle("R8 R7 only highest flag");
    step('0, 0, '0, 0, 0, 1, '0, 0, '0, "R7 mask all off");
    idle("R7 no request when masked");
    step('0, 1, 6'd40, 1, 0, 0, '0, 0, '0, "R2 masked flag still testable");
    step('0, 1, 6'd63, 0, 1, 1, '1, 0, '0, "R3 R4 clear 63 not taken");
    idle("R8 lowest after clears");
    do_reset();
    idle("R1 reset clears flags");
    step('0, 1, 6'd3, 1, 0, 0, '0, 0, '0, "R1 flag 3 cleared by reset");
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule